// File: doc/BRIEF.md
# Critical-Word-First Line Fill Unit

This unit services instruction-cache misses. A miss address enters a small two-slot queue; the oldest queued miss becomes the active fill, which reads its eight-word line from a word-wide memory port. The word that missed is read first. The remaining seven words follow in wrapping order inside the line-aligned block. Each returned word goes to the line buffer write port together with its index, the line base address and an even parity bit. The first returned word is also passed to the requester in the cycle it arrives.

The memory port has one word outstanding at a time. The unit holds a read request valid with a stable address until the memory raises a response-valid strobe for one cycle with the data. One cycle after the eighth word is written, the unit pulses a line-valid strobe for that line and starts the next queued miss. While a fill is in progress, the lookup path may keep hitting. A dependency input from outside blocks that, and the unit reports the result on a hit-permission output.

Top module: `cwf_fill_unit`

## Requirements
- R1: While reset is held, no memory request, no line write, no forwarded word and no line-valid strobe is driven; miss_ready is 1 and hit_allowed is 1.
- R2: The first memory read of a fill addresses the missed word itself (miss address with byte offset bits [1:0] cleared).
- R3: For a missed word index c (address bits [4:2]), the line words are read and written in the index order c, c+1, ..., 7, 0, ..., c-1, each read at line base plus index*4.
- R4: crit_valid is 1 exactly in the cycle the first word of a fill is returned, and crit_data then equals the returned data.
- R5: Every returned word is written in its arrival cycle, with wr_idx, wr_data equal to the returned data, and wr_line_addr equal to the miss address with bits [4:0] cleared.
- R6: wr_parity is the even parity bit of wr_data, so the 33 bits together hold an even number of ones.
- R7: line_valid_set pulses for one cycle, with line_valid_addr equal to the line base, in the cycle after the eighth word write of a fill and at no other time.
- R8: The queue holds two misses, counting the fill in progress; with two pending, miss_ready is 0 and a further miss waits until a fill completes.
- R9: Queued misses are filled in the order they were accepted.
- R10: hit_allowed is 0 only while a fill is pending and dep_hold is 1.
- R11: While a read request waits for its response, mem_req_valid stays 1 and mem_req_addr does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_addr | input | 32 | Byte address of the missed word |
| miss_ready | output | 1 | Queue can accept a miss this cycle |
| dep_hold | input | 1 | Lookup depends on data still being filled |
| hit_allowed | output | 1 | Lookup may proceed this cycle |
| mem_req_valid | output | 1 | Memory read request pending |
| mem_req_addr | output | 32 | Byte address of requested word |
| mem_rsp_valid | input | 1 | Memory data valid this cycle |
| mem_rsp_data | input | 32 | Memory read data |
| crit_valid | output | 1 | Missed word forwarded this cycle |
| crit_data | output | 32 | Forwarded missed word |
| wr_en | output | 1 | Line buffer word write |
| wr_idx | output | 3 | Word index within the line |
| wr_data | output | 32 | Word written |
| wr_parity | output | 1 | Even parity of wr_data |
| wr_line_addr | output | 32 | Line base address of the write |
| line_valid_set | output | 1 | Line complete, set its valid bit |
| line_valid_addr | output | 32 | Line base address being validated |

## Verification
The word write, its parity and the forwarded word are combinational from the response, so the bench checks them at the falling edge of the same cycle the memory raises mem_rsp_valid. The line-valid strobe passes through one register and is checked at the falling edge one cycle after the eighth write. miss_ready and hit_allowed depend only on registered queue state and dep_hold, so they are sampled at the falling edge before the rising edge that would act on them. The bench memory changes its response one time unit after each rising edge, so the design never sees a change right at an active edge.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  localparam int CWF_ADDR_W      = 32;
  localparam int CWF_DATA_W      = 32;
  localparam int CWF_LINE_WORDS  = 8;
  localparam int CWF_QUEUE_DEPTH = 2;
endpackage

// File: rtl/cwf_miss_queue.sv
module cwf_miss_queue #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) wr_ptr_d = ptr_inc(wr_ptr_q);
    if (pop)  rd_ptr_d = ptr_inc(rd_ptr_q);
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_ptr_q] <= push_data;
  end

  assign head_data = slot_q[rd_ptr_q];
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/cwf_beat_seq.sv
module cwf_beat_seq #(
  parameter int WORDS = 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [IDX_W-1:0] crit_idx,
  output logic [IDX_W-1:0] word_idx,
  output logic             first_beat,
  output logic             last_beat
);
  logic [IDX_W-1:0] beat_q, beat_d;

  assign first_beat = (beat_q == '0);
  assign last_beat  = (beat_q == IDX_W'(WORDS - 1));
  // WORDS is a power of two, so the IDX_W-bit sum wraps inside the line
  assign word_idx   = crit_idx + beat_q;

  always_comb begin
    beat_d = beat_q;
    if (step) beat_d = last_beat ? '0 : beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= beat_d;
  end
endmodule

// File: rtl/cwf_parity_gen.sv
module cwf_parity_gen #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] data,
  output logic              par
);
  assign par = ^data;
endmodule

// File: rtl/cwf_fill_unit.sv
module cwf_fill_unit
  import cwf_pkg::*;
#(
  parameter int ADDR_W      = CWF_ADDR_W,
  parameter int DATA_W      = CWF_DATA_W,
  parameter int LINE_WORDS  = CWF_LINE_WORDS,
  parameter int QUEUE_DEPTH = CWF_QUEUE_DEPTH,
  localparam int IDX_W      = $clog2(LINE_WORDS),
  localparam int OFF_W      = $clog2(DATA_W / 8),
  localparam int LINE_OFF_W = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              miss_ready,
  input  logic              dep_hold,
  output logic              hit_allowed,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              crit_valid,
  output logic [DATA_W-1:0] crit_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_parity,
  output logic [ADDR_W-1:0] wr_line_addr,
  output logic              line_valid_set,
  output logic [ADDR_W-1:0] line_valid_addr
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] head_addr, line_base;
  logic              q_empty, q_full, busy, accept, push, pop;
  logic [IDX_W-1:0]  crit_idx, word_idx;
  logic              first_beat, last_beat;
  logic              done_q, done_d;
  logic [ADDR_W-1:0] done_addr_q, done_addr_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign push       = miss_valid && !q_full;
  assign miss_ready = !q_full;

  cwf_miss_queue #(.WIDTH(ADDR_W), .DEPTH(QUEUE_DEPTH)) queue_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .push     (push),
    .push_data(miss_addr),
    .pop      (pop),
    .head_data(head_addr),
    .empty    (q_empty),
    .full     (q_full)
  );

  assign busy      = !q_empty;
  assign crit_idx  = head_addr[OFF_W +: IDX_W];
  assign line_base = head_addr & ~ADDR_W'((1 << LINE_OFF_W) - 1);
  assign accept    = busy && mem_rsp_valid;
  assign pop       = accept && last_beat;

  cwf_beat_seq #(.WORDS(LINE_WORDS)) seq_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .step      (accept),
    .crit_idx  (crit_idx),
    .word_idx  (word_idx),
    .first_beat(first_beat),
    .last_beat (last_beat)
  );

  cwf_parity_gen #(.DATA_W(DATA_W)) par_i (
    .data(mem_rsp_data),
    .par (wr_parity)
  );

  assign mem_req_valid = busy;
  assign mem_req_addr  = line_base | (ADDR_W'(word_idx) << OFF_W);

  assign wr_en        = accept;
  assign wr_idx       = word_idx;
  assign wr_data      = mem_rsp_data;
  assign wr_line_addr = line_base;
  assign crit_valid   = accept && first_beat;
  assign crit_data    = mem_rsp_data;
  assign hit_allowed  = !(busy && dep_hold);

  always_comb begin
    done_d      = pop;
    done_addr_d = done_addr_q;
    if (pop) done_addr_d = line_base;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      done_q      <= 1'b0;
      done_addr_q <= '0;
    end else begin
      done_q      <= done_d;
      done_addr_q <= done_addr_d;
    end
  end

  assign line_valid_set  = done_q;
  assign line_valid_addr = done_addr_q;
endmodule

// File: rtl/cwf_fill_unit_chk.sv
module cwf_fill_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dep_hold,
  input logic              hit_allowed,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              crit_valid,
  input logic              wr_en,
  input logic              line_valid_set
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_crit_on_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    crit_valid |-> (mem_rsp_valid && wr_en));

  p_write_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (mem_req_valid && mem_rsp_valid));

  p_valid_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid_set |-> $past(wr_en));

  p_hit_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_allowed |-> (dep_hold && mem_req_valid));
endmodule

bind cwf_fill_unit cwf_fill_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .dep_hold      (dep_hold),
  .hit_allowed   (hit_allowed),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .crit_valid    (crit_valid),
  .wr_en         (wr_en),
  .line_valid_set(line_valid_set)
);

// File: tb/cwf_fill_unit_tb_top.sv
`timescale 1ns/1ps
module cwf_fill_unit_tb_top;
  logic        clk, rst_n;
  logic        miss_valid, dep_hold, mem_rsp_valid;
  logic [31:0] miss_addr, mem_rsp_data;
  logic        miss_ready, hit_allowed, mem_req_valid, crit_valid, wr_en, wr_parity, line_valid_set;
  logic [31:0] mem_req_addr, crit_data, wr_data, wr_line_addr, line_valid_addr;
  logic [2:0]  wr_idx;

  int n_checks = 0, n_fail = 0;
  int lat = 0;
  int fills_done = 0;
  logic [31:0] exp_q [16];
  int exp_wr = 0, exp_rd = 0, beat = 0;
  bit done_pending = 0;
  logic [31:0] done_line;

  localparam int NV = 5;
  localparam logic [31:0] VEC_ADDR [NV] = '{32'h0000_1000, 32'h0000_203C, 32'h0001_0a4c, 32'h8000_0074, 32'hFFFF_FFE6};
  localparam int VEC_LAT [NV] = '{0, 2, 1, 3, 0};

  cwf_fill_unit dut_i (.*);

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] p;
    p = a * 32'h9E37_79B1;
    return p ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // memory model: changes one time unit after each rising edge
  initial begin
    int cnt = 0;
    mem_rsp_valid = 0;
    mem_rsp_data  = '0;
    forever begin
      @(posedge clk); #1;
      if (mem_rsp_valid) begin
        mem_rsp_valid = 0;
        cnt = lat;
      end else if (mem_req_valid && rst_n) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data  = mem_word(mem_req_addr);
        end else cnt--;
      end
    end
  end

  // monitor at falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (done_pending) begin
          chk(line_valid_set == 1'b1, "R7 line valid strobe", {31'b0, line_valid_set}, 32'd1);
          chk(line_valid_addr == done_line, "R7 line valid addr", line_valid_addr, done_line);
          done_pending = 0;
          fills_done++;
        end else if (line_valid_set) begin
          chk(1'b0, "R7 unexpected line valid", 32'd1, 32'd0);
        end
        if (crit_valid && !wr_en) chk(1'b0, "R4 forward without write", 32'd1, 32'd0);
        if (wr_en) begin
          logic [31:0] a, base, ea, ed;
          logic [2:0]  ei;
          a    = exp_q[exp_rd % 16];
          base = {a[31:5], 5'b0};
          ei   = a[4:2] + 3'(beat);
          ea   = base | {27'b0, ei, 2'b0};
          ed   = mem_word(ea);
          chk(wr_idx == ei, "R3 wrap order index", {29'b0, wr_idx}, {29'b0, ei});
          chk(wr_data == ed, (beat == 0) ? "R2 critical word first" : "R3 wrapped word data", wr_data, ed);
          chk(wr_line_addr == base, "R5 R9 line address", wr_line_addr, base);
          chk(wr_parity == ^ed, "R6 even parity", {31'b0, wr_parity}, {31'b0, ^ed});
          if (beat == 0) begin
            chk(crit_valid && crit_data == ed, "R4 critical forward", crit_data, ed);
          end else begin
            chk(!crit_valid, "R4 no forward on later beats", {31'b0, crit_valid}, 32'd0);
          end
          beat++;
          if (beat == 8) begin
            beat = 0;
            exp_rd++;
            done_pending = 1;
            done_line = base;
          end
        end
      end
    end
  end

  task automatic issue(input logic [31:0] a, output int stalls);
    stalls = 0;
    @(negedge clk);
    miss_valid = 1;
    miss_addr  = a;
    while (!miss_ready) begin
      stalls++;
      @(negedge clk);
    end
    exp_q[exp_wr % 16] = a;
    exp_wr++;
    @(posedge clk); #1;
    miss_valid = 0;
  endtask

  task automatic wait_fills(input int target);
    while (fills_done < target) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int st;
    miss_valid = 0; miss_addr = '0; dep_hold = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!mem_req_valid && !wr_en && !crit_valid && !line_valid_set, "R1 idle outputs in reset",
        {28'b0, mem_req_valid, wr_en, crit_valid, line_valid_set}, 32'd0);
    chk(miss_ready, "R1 ready in reset", {31'b0, miss_ready}, 32'd1);
    dep_hold = 1;
    #1;
    chk(hit_allowed, "R1 hit allowed in reset", {31'b0, hit_allowed}, 32'd1);
    dep_hold = 0;
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      lat = VEC_LAT[i];
      issue(VEC_ADDR[i], st);
      wait_fills(exp_wr);
    end

    // R10 dependency hold idle vs busy
    dep_hold = 1;
    @(negedge clk);
    chk(hit_allowed, "R10 idle hit with dep_hold", {31'b0, hit_allowed}, 32'd1);
    lat = 2;
    issue(32'h0000_4418, st);
    @(negedge clk);
    chk(!hit_allowed, "R10 blocked while busy", {31'b0, hit_allowed}, 32'd0);
    dep_hold = 0;
    #1;
    chk(hit_allowed, "R10 allowed busy no dep", {31'b0, hit_allowed}, 32'd1);
    wait_fills(exp_wr);

    // R8 queue full and third miss stalls, R9 order
    lat = 1;
    issue(32'h0000_5004, st);
    chk(st == 0, "R8 first accepted", st, 0);
    issue(32'h0000_6010, st);
    chk(st == 0, "R8 second accepted", st, 0);
    @(negedge clk);
    chk(!miss_ready, "R8 full with two pending", {31'b0, miss_ready}, 32'd0);
    issue(32'h0000_701C, st);
    chk(st > 0, "R8 third miss stalled", st, 1);
    wait_fills(exp_wr);
    @(negedge clk);
    chk(miss_ready && !mem_req_valid, "R8 queue drained", {30'b0, miss_ready, mem_req_valid}, 32'd2);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule